// File: doc/BRIEF.md
# Repeated String Move Engine

This block is a hardware sequencer for a whole string copy or string compare. Software first writes three working registers through a plain load port: a source pointer, a destination pointer and an element count. A single start pulse, carrying a command byte and a mode bit, then runs the complete operation with no further commands. Each step moves or compares one byte. The three registers are updated in place as the work proceeds, so their final values can be read back at any time.

The engine has one byte-wide memory port with a valid/ready request channel. The engine raises `mem_valid` and holds the address, direction and write data until the memory accepts the request with `mem_ready`. Read data is taken from `mem_rdata` in the same cycle that a read is accepted. The memory may hold `mem_ready` low for any number of cycles, and the engine waits without changing the request. The engine never withdraws a request it has raised.

In copy mode, each byte is read at the source pointer and then written at the destination pointer. In compare mode, both bytes are read and compared, and the operation ends early at the first difference.

Top module: `strmove_engine`

## Requirements
- R1: After reset `busy`, `done`, `mismatch` and `mem_valid` are 0, and the source, destination and count registers read 0.
- R2: A start pulse is accepted only when `cmd_code` is 8'hF2 or 8'hA4 and the engine is idle. With any other code the pulse is ignored: `busy` stays 0 and no memory request is made.
- R3: When the engine is idle, `load_en` writes `load_src`, `load_dst` and `load_cnt`, and the new values show on the register outputs after the next clock edge. While `busy` is 1, `load_en` is ignored.
- R4: In copy mode (`mode`=0), each byte is first a read at the source pointer and then a write of that same byte at the destination pointer. After the second access is accepted, both pointers increase by 1 and the count decreases by 1.
- R5: If the count is 0 when a start is accepted, no memory request is made, `busy` stays 0, and `done` is 1 for exactly the cycle after the start edge.
- R6: While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` keep their values into the next cycle.
- R7: In compare mode (`mode`=1), each byte is a read at the source pointer followed by a read at the destination pointer, and `mem_we` stays 0. When the two bytes differ, the engine stops with `mismatch`=1. The pointers are left one past the differing byte, and the count is decreased for that byte as well.
- R8: A compare in which every byte matches runs until the count reaches 0 and ends with `mismatch`=0. The `mismatch` flag is cleared whenever a start is accepted.
- R9: `busy` is 1 from the cycle after an accepted start with a nonzero count until the last access is accepted. `done` pulses for one cycle as `busy` falls. A start pulse while `busy` is 1 has no effect.
- R10: `mode` is sampled only when a start is accepted. Changing `mode` during an operation does not change the type of access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse |
| cmd_code | input | 8 | Command byte checked at start |
| mode | input | 1 | 0 = copy, 1 = compare |
| load_en | input | 1 | Write the three working registers |
| load_src | input | AW | Source pointer value to load |
| load_dst | input | AW | Destination pointer value to load |
| load_cnt | input | CW | Count value to load |
| src_ptr | output | AW | Current source pointer |
| dst_ptr | output | AW | Current destination pointer |
| count | output | CW | Remaining element count |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mismatch | output | 1 | Last compare found a difference |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | DW | Read data, valid when a read is accepted |

## Verification
A sequencer that lands in the wrong phase shows up immediately. In the very next cycle, `mem_we` or `mem_addr` points at the wrong pointer or the wrong direction, and a copy then writes stale data to the destination. A pointer or count that steps wrongly shows on the register outputs in the cycle after the access is accepted. It also moves every later address, so the error grows over the rest of the string. A lost or stuck `mismatch` or `done` shows at the end of the operation, and the bench compares every output against its reference model on every cycle.

// File: rtl/strmove_pkg.sv
package strmove_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_FIRST  = 2'd1,
    SEQ_SECOND = 2'd2
  } seq_state_t;

  localparam int NUM_CODES = 2;
  localparam logic [7:0] ACCEPT_CODES [NUM_CODES] = '{8'hF2, 8'hA4};
endpackage

// File: rtl/strmove_regs.sv
module strmove_regs #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          load_en,
  input  logic [AW-1:0] load_src,
  input  logic [AW-1:0] load_dst,
  input  logic [CW-1:0] load_cnt,
  input  logic          step,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [CW-1:0] cnt_q,
  output logic          cnt_zero,
  output logic          cnt_one
);
  localparam logic [AW-1:0] PTR_INC = AW'(1);
  localparam logic [CW-1:0] CNT_DEC = CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
    end else if (step) begin
      src_q <= src_q + PTR_INC;
      dst_q <= dst_q + PTR_INC;
      cnt_q <= cnt_q - CNT_DEC;
    end else if (load_en && !busy) begin
      src_q <= load_src;
      dst_q <= load_dst;
      cnt_q <= load_cnt;
    end
  end

  assign cnt_zero = (cnt_q == '0);
  assign cnt_one  = (cnt_q == CNT_DEC);

  // R4: a step moves both pointers up and the count down by one
  p_step_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (src_q == $past(src_q) + PTR_INC) && (dst_q == $past(dst_q) + PTR_INC)
             && (cnt_q == $past(cnt_q) - CNT_DEC));

  // R3: loads have no effect while an operation runs
  p_load_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step) |=> $stable(src_q) && $stable(dst_q) && $stable(cnt_q));
endmodule

// File: rtl/strmove_hold.sv
module strmove_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] held,
  output logic          differs
);
  always_ff @(posedge clk) begin
    if (!rst_n)       held <= '0;
    else if (capture) held <= rdata;
  end

  assign differs = (held != rdata);
endmodule

// File: rtl/strmove_seq.sv
module strmove_seq
  import strmove_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] cmd_code,
  input  logic       mode,
  input  logic       cnt_zero,
  input  logic       cnt_one,
  input  logic       differs,
  input  logic       mem_ready,
  output logic       busy,
  output logic       done,
  output logic       mismatch,
  output logic       mem_valid,
  output logic       mem_we,
  output logic       sel_dst,
  output logic       capture,
  output logic       step
);
  seq_state_t state;
  logic       cmp_q;
  logic [NUM_CODES-1:0] code_hit;
  logic       accept;

  for (genvar i = 0; i < NUM_CODES; i++) begin : g_code
    assign code_hit[i] = (cmd_code == ACCEPT_CODES[i]);
  end

  assign accept    = start && (state == SEQ_IDLE) && (|code_hit);
  assign busy      = (state != SEQ_IDLE);
  assign mem_valid = busy;
  assign sel_dst   = (state == SEQ_SECOND);
  assign mem_we    = sel_dst && !cmp_q;
  assign capture   = (state == SEQ_FIRST) && mem_ready;
  assign step      = (state == SEQ_SECOND) && mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      done     <= 1'b0;
      mismatch <= 1'b0;
      cmp_q    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        SEQ_IDLE: begin
          if (accept) begin
            mismatch <= 1'b0;
            cmp_q    <= mode;
            if (cnt_zero) done  <= 1'b1;
            else          state <= SEQ_FIRST;
          end
        end
        SEQ_FIRST: begin
          if (mem_ready) state <= SEQ_SECOND;
        end
        SEQ_SECOND: begin
          if (mem_ready) begin
            if (cmp_q && differs) begin
              mismatch <= 1'b1;
              done     <= 1'b1;
              state    <= SEQ_IDLE;
            end else if (cnt_one) begin
              done  <= 1'b1;
              state <= SEQ_IDLE;
            end else begin
              state <= SEQ_FIRST;
            end
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // R5: a start with zero count finishes at once without a request
  p_zero_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cnt_zero) |=> done && !mem_valid);

  // R7: mismatch only rises together with the completion pulse
  p_mismatch_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mismatch) |-> done && !busy);

  // R9: a start while running does not end the operation early
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !step) |=> busy);
endmodule

// File: rtl/strmove_engine.sv
module strmove_engine #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    cmd_code,
  input  logic          mode,
  input  logic          load_en,
  input  logic [AW-1:0] load_src,
  input  logic [AW-1:0] load_dst,
  input  logic [CW-1:0] load_cnt,
  output logic [AW-1:0] src_ptr,
  output logic [AW-1:0] dst_ptr,
  output logic [CW-1:0] count,
  output logic          busy,
  output logic          done,
  output logic          mismatch,
  output logic          mem_valid,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata
);
  logic cnt_zero, cnt_one, differs, sel_dst, capture, step;

  strmove_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .load_en  (load_en),
    .load_src (load_src),
    .load_dst (load_dst),
    .load_cnt (load_cnt),
    .step     (step),
    .src_q    (src_ptr),
    .dst_q    (dst_ptr),
    .cnt_q    (count),
    .cnt_zero (cnt_zero),
    .cnt_one  (cnt_one)
  );

  strmove_hold #(.DW(DW)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .rdata   (mem_rdata),
    .held    (mem_wdata),
    .differs (differs)
  );

  strmove_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cmd_code  (cmd_code),
    .mode      (mode),
    .cnt_zero  (cnt_zero),
    .cnt_one   (cnt_one),
    .differs   (differs),
    .mem_ready (mem_ready),
    .busy      (busy),
    .done      (done),
    .mismatch  (mismatch),
    .mem_valid (mem_valid),
    .mem_we    (mem_we),
    .sel_dst   (sel_dst),
    .capture   (capture),
    .step      (step)
  );

  assign mem_addr = sel_dst ? dst_ptr : src_ptr;

  // R6: a stalled request is held unchanged
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> mem_valid && $stable(mem_we) && $stable(mem_addr)
                                  && $stable(mem_wdata));

  // R9: completion pulse only once idle
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/strmove_engine_bench.sv
module strmove_engine_bench;
  localparam int AW = 16, CW = 16, DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, mode = 1'b0, load_en = 1'b0, mem_ready = 1'b1;
  logic [7:0] cmd_code = 8'h00;
  logic [AW-1:0] load_src = '0, load_dst = '0;
  logic [CW-1:0] load_cnt = '0;
  logic [AW-1:0] src_ptr, dst_ptr, mem_addr;
  logic [CW-1:0] count;
  logic busy, done, mismatch, mem_valid, mem_we;
  logic [DW-1:0] mem_wdata, mem_rdata;

  always #2.5 clk = ~clk;

  strmove_engine #(.AW(AW), .CW(CW), .DW(DW)) u_strmove_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_code(cmd_code), .mode(mode),
    .load_en(load_en), .load_src(load_src), .load_dst(load_dst), .load_cnt(load_cnt),
    .src_ptr(src_ptr), .dst_ptr(dst_ptr), .count(count), .busy(busy), .done(done),
    .mismatch(mismatch), .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  int errors = 0, checks = 0, cycles = 0;
  int ready_kind = 0;
  logic [7:0] lfsr = 8'h5B;
  logic [7:0] bmem [0:255];
  assign mem_rdata = bmem[mem_addr[7:0]];

  // reference model state
  int ph = 0;
  bit m_cmp = 0, m_done = 0, m_mm = 0;
  int m_src = 0, m_dst = 0, m_cnt = 0;
  logic [7:0] m_hold = 8'h00;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      ph = 0; m_cmp = 0; m_done = 0; m_mm = 0; m_src = 0; m_dst = 0; m_cnt = 0; m_hold = 0;
    end else begin
      m_done = 0;
      if (ph == 0) begin
        if (start && (cmd_code == 8'hF2 || cmd_code == 8'hA4)) begin
          m_mm = 0; m_cmp = mode;
          if (m_cnt == 0) m_done = 1; else ph = 1;
        end else if (load_en) begin
          m_src = load_src; m_dst = load_dst; m_cnt = load_cnt;
        end
      end else if (ph == 1) begin
        if (mem_ready) begin m_hold = bmem[m_src & 255]; ph = 2; end
      end else if (mem_ready) begin
        bit neq;
        neq = (m_hold != bmem[m_dst & 255]);
        if (!m_cmp) bmem[m_dst & 255] = m_hold;
        m_src = (m_src + 1) & 16'hFFFF; m_dst = (m_dst + 1) & 16'hFFFF;
        m_cnt = (m_cnt - 1) & 16'hFFFF;
        if (m_cmp && neq) begin m_mm = 1; m_done = 1; ph = 0; end
        else if (m_cnt == 0) begin m_done = 1; ph = 0; end
        else ph = 1;
      end
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9", "busy", busy, ph != 0);
      chk("R9", "done", done, m_done);
      chk("R7", "mismatch", mismatch, m_mm);
      chk("R4", "src_ptr", src_ptr, m_src);
      chk("R4", "dst_ptr", dst_ptr, m_dst);
      chk("R4", "count", count, m_cnt);
      chk("R6", "mem_valid", mem_valid, ph != 0);
      if (ph != 0) begin
        chk("R10", "mem_we", mem_we, (ph == 2) && !m_cmp);
        chk("R4", "mem_addr", mem_addr, (ph == 1) ? m_src : m_dst);
        if (ph == 2 && !m_cmp) chk("R4", "mem_wdata", mem_wdata, m_hold);
      end
    end
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready <= (ready_kind == 0) ? 1'b1 : (ready_kind == 2) ? 1'b0 : (lfsr[0] | lfsr[1]);
  end

  always @(posedge clk) begin
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic load(input int s, input int d, input int c);
    @(negedge clk);
    load_en = 1; load_src = AW'(s); load_dst = AW'(d); load_cnt = CW'(c);
    @(negedge clk);
    load_en = 0;
  endtask

  task automatic kick(input logic [7:0] code, input logic md);
    @(negedge clk);
    start = 1; cmd_code = code; mode = md;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 8'((i * 7 + 3) & 255);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "busy", busy, 0); chk("R1", "done", done, 0);
    chk("R1", "mismatch", mismatch, 0); chk("R1", "mem_valid", mem_valid, 0);
    chk("R1", "count", count, 0);
    rst_n = 1;

    // R3 + R4: copy with random back-pressure
    ready_kind = 1;
    load(16'h0010, 16'h0080, 5);
    chk("R3", "loaded count", count, 5);
    kick(8'hA4, 0);
    wait_idle();
    for (int i = 0; i < 5; i++) chk("R4", "copied byte", bmem[8'h80 + i], bmem[8'h10 + i]);

    // R2: unknown code ignored
    load(16'h0020, 16'h00A0, 4);
    kick(8'h90, 0);
    chk("R2", "busy after bad code", busy, 0);
    chk("R2", "mem_valid after bad code", mem_valid, 0);

    // R6 + R9 + R10: stalled memory, extra start, mode flip and load while busy
    ready_kind = 2;
    kick(8'hF2, 0);
    mode = 1;
    repeat (4) @(negedge clk);
    chk("R6", "held valid", mem_valid, 1);
    chk("R6", "held addr", mem_addr, 16'h0020);
    start = 1; cmd_code = 8'hA4; load_en = 1; load_src = 16'h0055;
    @(negedge clk);
    start = 0; load_en = 0;
    ready_kind = 1;
    wait_idle();
    chk("R3", "src after busy load", src_ptr, 16'h0024);
    chk("R10", "copy kept after mode flip", bmem[8'hA3], bmem[8'h23]);

    // R5: zero count
    load(16'h0030, 16'h0040, 0);
    @(negedge clk);
    start = 1; cmd_code = 8'hA4; mode = 0;
    @(negedge clk);
    start = 0;
    chk("R5", "done next cycle", done, 1);
    chk("R5", "no request", mem_valid, 0);
    chk("R5", "busy low", busy, 0);

    // R7: compare with a difference at index 2
    for (int i = 0; i < 6; i++) bmem[8'hC0 + i] = bmem[8'h50 + i];
    bmem[8'hC2] = ~bmem[8'h52];
    load(16'h0050, 16'h00C0, 6);
    kick(8'hF2, 1);
    wait_idle();
    chk("R7", "mismatch flag", mismatch, 1);
    chk("R7", "src past diff", src_ptr, 16'h0053);
    chk("R7", "count left", count, 3);

    // R8: equal compare clears the flag and runs to zero
    load(16'h0050, 16'h00C0, 2);
    kick(8'hA4, 1);
    wait_idle();
    chk("R8", "mismatch clear", mismatch, 0);
    chk("R8", "count zero", count, 0);
    chk("R8", "dst end", dst_ptr, 16'h00C2);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule